// File: doc/BRIEF.md
# Serial Port Status and Interrupt Registers

This block holds the software-visible state of a simple serial port that buffers one character each way. A processor reaches it over a word-indexed register bus; the index is the byte offset divided by four. A receiver hands it characters with error and break flags, and line-monitoring logic reports events through per-bit set pulses. The block passes transmitted bytes to a transmitter as a one-cycle strobe and drives one level-sensitive interrupt line.

Software enables interrupt sources with bits in the first control word. Each enable bit sits at the same position as the status bit it gates. A separate transmit-empty enable does two things. When set, it adds the empty flag from the FIFO status word to the interrupt. When clear, it keeps transmit-ready out of the interrupt. Reading the receive word consumes the held character and clears the ready flags. Event bits in both status words are cleared by writing a 1 to them.

Top module: `serial_status_regs`

## Requirements
- R1: After reset the registers read as follows: status 1 (index 0x25) = 0x2000 (transmit ready), status 2 (index 0x26) = 0x4008 (transmit buffer empty bit 14, transmit complete bit 3), FIFO status (index 0x2D) = 0x0060 (transmit empty bit 6, receive empty bit 5), control 1 (index 0x20) = 0, receive word (index 0x00) = 0. The interrupt is low.
- R2: A receive strobe stores the receive word as follows: bit 15 = valid (1), bit 14 = error, bit 11 = break, bits 7:0 = the character. It also sets status 1 bit 9 and status 2 bit 0, clears FIFO status bit 5 and sets FIFO status bit 3 (receive full).
- R3: A read of index 0x00 returns the receive word. Once the character is consumed, status 1 bit 9, status 2 bit 0 and receive word bit 15 become 0, FIFO status bit 5 becomes 1 and bit 3 becomes 0. The error and break bits and the character stay in the word.
- R4: A write to status 1 clears each bit written as 1 within mask 0x9DB0. Every other bit keeps its value.
- R5: A write to status 2 clears each bit written as 1 within mask 0xBDD6. Bit 0 (receive data ready) and bit 3 (transmit complete) cannot be cleared by software.
- R6: Event pulses on the two event inputs set the matching status bits within the same masks (0x9DB0 and 0xBDD6). When a set and a software clear of the same bit fall in the same cycle, the set wins.
- R7: Writes to control 1 (index 0x20) and control 2 (index 0x21) keep only the low 16 bits, and a read returns them.
- R8: The interrupt is high when status 1 bit 9 and control 1 bit 9 are both set. It is also high when control 1 bit 6 is set and either FIFO status bit 6 is set or status 1 bit 13 and control 1 bit 13 are both set. When control 1 bit 6 is clear, transmit ready never raises the interrupt.
- R9: A write to index 0x10 while control 1 bit 0 is set raises the transmit strobe for exactly one cycle, starting the cycle after the write, with the low 8 data bits on the byte output. While control 1 bit 0 is clear, no strobe is raised.
- R10: Unmapped indices read as zero and ignore writes. Writes to the FIFO status word (index 0x2D) have no effect.
- R11: Read data is registered. It appears the cycle after the read enable is sampled and reflects the state before that read's side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (8) | Word index of the register |
| busWe | input | 1 | Write enable |
| busWdata | input | DATA_W (32) | Write data |
| busRe | input | 1 | Read enable |
| busRdata | output | DATA_W (32) | Registered read data |
| rxStrobe | input | 1 | Received character valid |
| rxChar | input | 8 | Received character |
| rxErr | input | 1 | Received character had an error |
| rxBrk | input | 1 | Break received |
| lineEvt1 | input | 16 | Set pulses for status 1 event bits |
| lineEvt2 | input | 16 | Set pulses for status 2 event bits |
| txStrobe | output | 1 | Transmit byte valid, one cycle |
| txByte | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
The interrupt combine is driven with several control words: receive ready alone, transmit ready without the empty enable, the empty enable alone, and all enables clear. These patterns separate the transmit-ready masking from the transmit-empty addition. Characters are received with the error flag, with the break flag, and with neither, which checks where each flag lands in the receive word. Status words are loaded with all-ones event pulses and then cleared one bit at a time and in full, which exposes any wrong mask bit or any software clear of the ready flags. A set and a clear are also made to collide in the same cycle to check that the set wins.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  parameter int REG_W = 16;

  parameter int IDX_RX    = 'h00;
  parameter int IDX_TX    = 'h10;
  parameter int IDX_CTRL1 = 'h20;
  parameter int IDX_CTRL2 = 'h21;
  parameter int IDX_STAT1 = 'h25;
  parameter int IDX_STAT2 = 'h26;
  parameter int IDX_FIFO  = 'h2D;

  parameter logic [REG_W-1:0] CLR1_MASK  = 16'h9DB0;
  parameter logic [REG_W-1:0] CLR2_MASK  = 16'hBDD6;
  parameter logic [REG_W-1:0] STAT1_RST  = 16'h2000;
  parameter logic [REG_W-1:0] STAT2_RST  = 16'h4008;

  parameter int B_TRDY   = 13;
  parameter int B_RRDY   = 9;
  parameter int B_TEMPEN = 6;
  parameter int B_EN     = 0;
  parameter int B_RDR    = 0;
  parameter int B_TXMT   = 6;
  parameter int B_RXMT   = 5;
  parameter int B_RXFULL = 3;

  typedef enum logic [2:0] {
    RS_NONE, RS_RX, RS_CTRL1, RS_CTRL2, RS_STAT1, RS_STAT2, RS_FIFO
  } rdSel_e;

  typedef struct packed {
    logic   wrTx;
    logic   wrCtrl1;
    logic   wrCtrl2;
    logic   wrStat1;
    logic   wrStat2;
    logic   rdRx;
    logic   rdEn;
    rdSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
  import sreg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output strobes_t          strb
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
    return a == ADDR_W'(idx);
  endfunction

  always_comb begin
    strb = '0;
    strb.wrTx    = busWe && hit(busAddr, IDX_TX);
    strb.wrCtrl1 = busWe && hit(busAddr, IDX_CTRL1);
    strb.wrCtrl2 = busWe && hit(busAddr, IDX_CTRL2);
    strb.wrStat1 = busWe && hit(busAddr, IDX_STAT1);
    strb.wrStat2 = busWe && hit(busAddr, IDX_STAT2);
    strb.rdRx    = busRe && hit(busAddr, IDX_RX);
    strb.rdEn    = busRe;
    if      (hit(busAddr, IDX_RX))    strb.rdSel = RS_RX;
    else if (hit(busAddr, IDX_CTRL1)) strb.rdSel = RS_CTRL1;
    else if (hit(busAddr, IDX_CTRL2)) strb.rdSel = RS_CTRL2;
    else if (hit(busAddr, IDX_STAT1)) strb.rdSel = RS_STAT1;
    else if (hit(busAddr, IDX_STAT2)) strb.rdSel = RS_STAT2;
    else if (hit(busAddr, IDX_FIFO))  strb.rdSel = RS_FIFO;
    else                              strb.rdSel = RS_NONE;
  end
endmodule

// File: rtl/sreg_datapath.sv
module sreg_datapath
  import sreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxStrobe,
  input  logic [7:0]        rxChar,
  input  logic              rxErr,
  input  logic              rxBrk,
  input  logic [REG_W-1:0]  lineEvt1,
  input  logic [REG_W-1:0]  lineEvt2,
  output logic              txStrobe,
  output logic [7:0]        txByte,
  output logic              irq
);
  localparam logic [REG_W-1:0] IRQ_SRC = REG_W'((1 << B_TRDY) | (1 << B_RRDY));

  logic [REG_W-1:0] ctrl1, ctrl2, stat1, stat2, rxWord, fifoStat;
  logic [REG_W-1:0] stat1Nxt, stat2Nxt, rxWordNxt, irqFlags;
  logic [REG_W-1:0] wrLow;
  logic             rxEmpty, rxEmptyNxt, rdConsume;

  assign wrLow     = busWdata[REG_W-1:0];
  assign rdConsume = strb.rdRx && !rxEmpty;

  always_comb begin
    fifoStat           = '0;
    fifoStat[B_TXMT]   = 1'b1;
    fifoStat[B_RXMT]   = rxEmpty;
    fifoStat[B_RXFULL] = !rxEmpty;
  end

  always_comb begin
    stat1Nxt   = stat1;
    stat2Nxt   = stat2;
    rxWordNxt  = rxWord;
    rxEmptyNxt = rxEmpty;
    if (strb.wrStat1) stat1Nxt = stat1Nxt & ~(wrLow & CLR1_MASK);
    if (strb.wrStat2) stat2Nxt = stat2Nxt & ~(wrLow & CLR2_MASK);
    stat1Nxt = stat1Nxt | (lineEvt1 & CLR1_MASK);
    stat2Nxt = stat2Nxt | (lineEvt2 & CLR2_MASK);
    if (rxStrobe) begin
      stat1Nxt[B_RRDY] = 1'b1;
      stat2Nxt[B_RDR]  = 1'b1;
      rxEmptyNxt       = 1'b0;
      rxWordNxt        = {1'b1, rxErr, 2'b00, rxBrk, 3'b000, rxChar};
    end else if (rdConsume) begin
      stat1Nxt[B_RRDY] = 1'b0;
      stat2Nxt[B_RDR]  = 1'b0;
      rxEmptyNxt       = 1'b1;
      rxWordNxt[15]    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrl1    <= '0;
      ctrl2    <= '0;
      stat1    <= STAT1_RST;
      stat2    <= STAT2_RST;
      rxWord   <= '0;
      rxEmpty  <= 1'b1;
      txStrobe <= 1'b0;
      txByte   <= '0;
      busRdata <= '0;
    end else begin
      stat1   <= stat1Nxt;
      stat2   <= stat2Nxt;
      rxWord  <= rxWordNxt;
      rxEmpty <= rxEmptyNxt;
      if (strb.wrCtrl1) ctrl1 <= wrLow;
      if (strb.wrCtrl2) ctrl2 <= wrLow;
      txStrobe <= strb.wrTx && ctrl1[B_EN];
      if (strb.wrTx && ctrl1[B_EN]) txByte <= busWdata[7:0];
      if (strb.rdEn) begin
        case (strb.rdSel)
          RS_RX:    busRdata <= DATA_W'(rxWord);
          RS_CTRL1: busRdata <= DATA_W'(ctrl1);
          RS_CTRL2: busRdata <= DATA_W'(ctrl2);
          RS_STAT1: busRdata <= DATA_W'(stat1);
          RS_STAT2: busRdata <= DATA_W'(stat2);
          RS_FIFO:  busRdata <= DATA_W'(fifoStat);
          default:  busRdata <= '0;
        endcase
      end
    end
  end

  always_comb begin
    irqFlags = stat1 & ctrl1 & IRQ_SRC;
    if (ctrl1[B_TEMPEN]) irqFlags[B_TXMT] = fifoStat[B_TXMT];
    else                 irqFlags[B_TRDY] = 1'b0;
  end
  assign irq = |irqFlags;

  assert_rx_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxStrobe |=> stat1[B_RRDY] && stat2[B_RDR] && !rxEmpty);

  assert_rd_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdRx && !rxStrobe) |=> !stat1[B_RRDY] && !stat2[B_RDR] && rxEmpty);

  assert_rdr_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStat2 && !rxStrobe && !strb.rdRx) |=> stat2[B_RDR] == $past(stat2[B_RDR]));

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl1[B_TEMPEN] && !ctrl1[B_RRDY]) |-> !irq);

  assert_tx_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    txStrobe |-> $past(strb.wrTx));
endmodule

// File: rtl/serial_status_regs.sv
module serial_status_regs
  import sreg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxStrobe,
  input  logic [7:0]        rxChar,
  input  logic              rxErr,
  input  logic              rxBrk,
  input  logic [15:0]       lineEvt1,
  input  logic [15:0]       lineEvt2,
  output logic              txStrobe,
  output logic [7:0]        txByte,
  output logic              irq
);
  strobes_t strb;

  sreg_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr(busAddr), .busWe(busWe), .busRe(busRe), .strb(strb)
  );

  sreg_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .busRdata(busRdata), .rxStrobe(rxStrobe), .rxChar(rxChar),
    .rxErr(rxErr), .rxBrk(rxBrk), .lineEvt1(lineEvt1), .lineEvt2(lineEvt2),
    .txStrobe(txStrobe), .txByte(txByte), .irq(irq)
  );
endmodule

// File: tb/serial_status_regs_test.sv
module serial_status_regs_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic        rxStrobe = 1'b0;
  logic [7:0]  rxChar = '0;
  logic        rxErr = 1'b0;
  logic        rxBrk = 1'b0;
  logic [15:0] lineEvt1 = '0;
  logic [15:0] lineEvt2 = '0;
  logic        txStrobe;
  logic [7:0]  txByte;
  logic        irq;

  int checks = 0;
  int fails = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        sawRead = 1'b0;

  serial_status_regs uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .busRdata(busRdata),
    .rxStrobe(rxStrobe), .rxChar(rxChar), .rxErr(rxErr), .rxBrk(rxBrk),
    .lineEvt1(lineEvt1), .lineEvt2(lineEvt2), .txStrobe(txStrobe),
    .txByte(txByte), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: a read sampled at a rising edge is compared at the next falling edge.
  always @(posedge clk) sawRead <= busRe;
  always @(negedge clk) begin
    if (sawRead && expQ.size() > 0) begin
      check(tagQ.pop_front(), busRdata, expQ.pop_front());
    end
  end

  task automatic rd(input logic [7:0] idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    busAddr = idx; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic wr(input logic [7:0] idx, input logic [31:0] val);
    @(negedge clk);
    busAddr = idx; busWe = 1'b1; busWdata = val;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rx(input logic [7:0] ch, input logic e, input logic b);
    @(negedge clk);
    rxStrobe = 1'b1; rxChar = ch; rxErr = e; rxBrk = b;
    @(negedge clk);
    rxStrobe = 1'b0; rxErr = 1'b0; rxBrk = 1'b0;
  endtask

  task automatic evt(input logic [15:0] e1, input logic [15:0] e2);
    @(negedge clk);
    lineEvt1 = e1; lineEvt2 = e2;
    @(negedge clk);
    lineEvt1 = '0; lineEvt2 = '0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    rd('h25, 32'h2000, "R1 stat1");
    rd('h26, 32'h4008, "R1 stat2");
    rd('h2D, 32'h0060, "R1 fifo");
    rd('h20, 32'h0000, "R1 ctrl1");
    rd('h00, 32'h0000, "R1 rxword");

    // R7 control width
    wr('h21, 32'hFFFF_1234);
    rd('h21, 32'h1234, "R7 ctrl2");
    wr('h20, 32'hFFFF_0000);
    rd('h20, 32'h0000, "R7 ctrl1 high bits");

    // R8 interrupt combine
    wr('h20, 32'h2000);
    check("R8 trdy masked", 32'(irq), 0);
    wr('h20, 32'h2040);
    check("R8 temp enable", 32'(irq), 1);
    wr('h20, 32'h0040);
    check("R8 empty alone", 32'(irq), 1);
    wr('h20, 32'h0201);
    check("R8 rx idle", 32'(irq), 0);

    // R2 / R3 receive path
    rx(8'h5A, 1'b1, 1'b0);
    check("R8 rx ready irq", 32'(irq), 1);
    rd('h25, 32'h2200, "R2 stat1");
    rd('h26, 32'h4009, "R2 stat2");
    rd('h2D, 32'h0048, "R2 fifo");
    rd('h00, 32'hC05A, "R11 R3 rxword pre-clear");
    @(negedge clk);
    check("R3 irq cleared", 32'(irq), 0);
    rd('h25, 32'h2000, "R3 stat1");
    rd('h26, 32'h4008, "R3 stat2");
    rd('h2D, 32'h0060, "R3 fifo");
    rd('h00, 32'h405A, "R3 valid dropped");
    rx(8'hA5, 1'b0, 1'b1);
    rd('h00, 32'h88A5, "R2 break word");

    // R9 transmit
    wr('h20, 32'h0001);
    @(negedge clk);
    busAddr = 'h10; busWe = 1'b1; busWdata = 32'h0000_01C3;
    @(negedge clk);
    busWe = 1'b0;
    check("R9 strobe", 32'(txStrobe), 1);
    check("R9 byte", 32'(txByte), 32'hC3);
    @(negedge clk);
    check("R9 one cycle", 32'(txStrobe), 0);
    wr('h20, 32'h0000);
    @(negedge clk);
    busAddr = 'h10; busWe = 1'b1; busWdata = 32'h77;
    @(negedge clk);
    busWe = 1'b0;
    check("R9 disabled", 32'(txStrobe), 0);

    // R6 / R4 / R5 status bits
    evt(16'hFFFF, 16'hFFFF);
    rd('h25, 32'hBDB0, "R6 stat1 set");
    rd('h26, 32'hFDDE, "R6 stat2 set");
    wr('h25, 32'h0000_0400);
    rd('h25, 32'hB9B0, "R4 single clear");
    wr('h25, 32'hFFFF_FFFF);
    rd('h25, 32'h2000, "R4 full clear");
    wr('h26, 32'hFFFF);
    rd('h26, 32'h4008, "R5 full clear");
    rx(8'h11, 1'b0, 1'b0);
    wr('h26, 32'hFFFF);
    rd('h26, 32'h4009, "R5 rdr kept");
    rd('h00, 32'h8011, "R3 consume");
    @(negedge clk);
    busAddr = 'h25; busWe = 1'b1; busWdata = 32'h0400; lineEvt1 = 16'h0400;
    @(negedge clk);
    busWe = 1'b0; lineEvt1 = '0;
    rd('h25, 32'h2400, "R6 set wins");
    wr('h25, 32'h0400);

    // R10 unmapped and read-only
    wr('h15, 32'hFFFF);
    rd('h15, 32'h0, "R10 unmapped");
    wr('h2D, 32'h0);
    rd('h2D, 32'h0060, "R10 fifo write ignored");
    rd('h25, 32'h2000, "R10 stat1 untouched");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule